// File: doc/BRIEF.md
# MDIO Register Access Master

This block is a management-bus master that reads and writes 16-bit registers inside a board controller over a two-wire MDIO link. The controller has a 10-bit register space. Each request address is split across the two 5-bit address fields of a standard management frame: the upper five bits go into the PHY field and the lower five bits go into the register field.

A requester raises a one-cycle strobe together with a direction bit, an address and write data. The block then runs the whole frame on its own and answers with a one-cycle completion pulse. Read data and an error flag are valid while that pulse is high. The MDC clock comes from a programmable half-period divider. MDIO leaves the block as a separate output value, an output-enable and an input, so a pad or tristate buffer can be placed outside.

Two behaviours cover the controller's quirks. First, reads in the upper region of its address space are not reliable on the first access, so a read at 0x300 or above runs two full frames back to back and returns only the second result. Second, if no device answers the turnaround of a read, the master clocks the bus to recover it and then reports all ones with an error.

Top module: `mdio_reg_master`

## Requirements
- R1: While reset is asserted and after it is released with no request, MDC is low, MDIO is released (output-enable 0), busy is 0 and done is 0.
- R2: Each frame begins with 32 MDC cycles in which MDIO is driven to 1, followed by two start bits, 0 and then 1.
- R3: After the start bits come the opcode (read = 10, write = 01), then request address bits [9:5], then request address bits [4:0]. Each field is sent MSB first.
- R4: A write then drives turnaround bits 1 and 0 and the 16 write-data bits MSB first. It then releases MDIO for one more MDC cycle before completing. A write frame lasts 65 MDC cycles in total.
- R5: A read releases MDIO right after the register field and clocks two turnaround cycles. If the second turnaround bit is sampled as 0, the master samples 16 data bits MSB first, each at the end of the MDC high phase. It then clocks two closing cycles (66 MDC cycles in total) and completes with that data and error 0.
- R6: If the second turnaround bit of a read is sampled as 1, the master clocks 32 more MDC cycles with MDIO released (80 MDC cycles in total). It then completes with read data 0xFFFF and error 1.
- R7: A read whose address is 0x300 or above runs two complete read frames back to back and returns only the result of the second frame.
- R8: Each MDC low phase and each MDC high phase lasts half_period system clocks, and a half_period of 0 acts as 1. MDIO output and output-enable change only on edges after which MDC is low.
- R9: busy is high from the clock edge that accepts a request until the edge that raises done. done is a single-cycle pulse. A request strobe that arrives while busy is high is ignored and leaves no pending work.
- R10: A write to an address of 0x300 or above runs a single frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, accepted when not busy |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Controller register address |
| req_wdata | input | 16 | Write data |
| half_period | input | 16 | System clocks per MDC phase (0 acts as 1) |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven while enabled |
| mdio_oe | output | 1 | MDIO output-enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| err | output | 1 | No responder on the last read, valid with done |

## Verification
The bench drives read and write frames at low and high addresses, at several divider settings including 0, and with the responder both present and absent. It compares every pin against a cycle-exact model on every clock. A design that sampled the turnaround on the wrong edge or skipped the recovery clocks would finish an absent-responder read early, or without 0xFFFF. A design that forgot the double read at 0x300 and above would return the deliberately different first-frame data, or finish after half the expected time. A request poked mid-frame must neither disturb the waveform nor start a second transaction afterwards. Likewise, a divider that treated 0 literally would stretch MDC far past the expected edges.

// File: rtl/mdio_reg_pkg.sv
package mdio_reg_pkg;
  localparam int ADDR_W      = 10;
  localparam int DATA_W      = 16;
  localparam int PRE_SLOTS   = 32;
  localparam int HDR_BITS    = 4 + ADDR_W;
  localparam int RECOV_SLOTS = 32;
  localparam int CNT_W       = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_HDR, S_WTA, S_WDAT, S_WREL,
    S_RTA, S_RDAT, S_RCLS, S_RREC
  } seq_state_t;

  // start pattern, opcode, then address: the upper half lands in the PHY
  // field and the lower half in the register field
  function automatic logic [HDR_BITS-1:0] mk_hdr(logic wr, logic [ADDR_W-1:0] a);
    return {2'b01, (wr ? 2'b01 : 2'b10), a};
  endfunction
endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_period,
  output logic             mdc,
  output logic             slot_end
);
  logic [DIV_W-1:0] cnt_q, cnt_d, limit;
  logic             mdc_q, mdc_d, at_lim;

  assign limit  = (half_period == '0) ? DIV_W'(1) : half_period;
  assign at_lim = (cnt_q == limit - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (at_lim) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign slot_end = run & mdc_q & at_lim;

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_reg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DOUBLE_BASE = 10'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              slot_end,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  seq_state_t          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [HDR_BITS-1:0] hdr_q, hdr_d;
  logic [DATA_W-1:0]   wsh_q, wsh_d, rsh_q, rsh_d, rdata_q, rdata_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic wr_q, wr_d, again_q, again_d, o_q, o_d, oe_q, oe_d;
  logic done_q, done_d, err_q, err_d;
  logic fin, fin_upd, fin_err;
  logic [DATA_W-1:0] fin_rd;

  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;   hdr_d = hdr_q;   wsh_d = wsh_q;
    rsh_d   = rsh_q;    rdata_d = rdata_q; addr_d = addr_q; wr_d = wr_q;
    again_d = again_q;  o_d = o_q;       oe_d = oe_q;     err_d = err_q;
    done_d  = 1'b0;
    fin = 1'b0; fin_upd = 1'b0; fin_err = 1'b0; fin_rd = '1;
    if (state_q == S_IDLE) begin
      if (start) begin
        state_d = S_PRE;  cnt_d = '0;
        wr_d = wr;  addr_d = addr;  wsh_d = wdata;
        hdr_d = mk_hdr(wr, addr);
        again_d = !wr && (addr >= DOUBLE_BASE);
        o_d = 1'b1;  oe_d = 1'b1;
      end
    end else if (slot_end) begin
      unique case (state_q)
        S_PRE: begin
          if (cnt_q == CNT_W'(PRE_SLOTS-1)) begin
            state_d = S_HDR;  cnt_d = '0;
            o_d = hdr_q[HDR_BITS-1];  hdr_d = hdr_q << 1;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_HDR: begin
          if (cnt_q == CNT_W'(HDR_BITS-1)) begin
            cnt_d = '0;
            if (wr_q) begin state_d = S_WTA; o_d = 1'b1; end
            else      begin state_d = S_RTA; oe_d = 1'b0; end
          end else begin
            cnt_d = cnt_q + 1'b1;
            o_d = hdr_q[HDR_BITS-1];  hdr_d = hdr_q << 1;
          end
        end
        S_WTA: begin
          if (cnt_q == '0) begin cnt_d = CNT_W'(1); o_d = 1'b0; end
          else begin
            state_d = S_WDAT;  cnt_d = '0;
            o_d = wsh_q[DATA_W-1];  wsh_d = wsh_q << 1;
          end
        end
        S_WDAT: begin
          if (cnt_q == CNT_W'(DATA_W-1)) begin
            state_d = S_WREL;  cnt_d = '0;  oe_d = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
            o_d = wsh_q[DATA_W-1];  wsh_d = wsh_q << 1;
          end
        end
        S_WREL: fin = 1'b1;
        S_RTA: begin
          if (cnt_q == '0) cnt_d = CNT_W'(1);
          else begin
            cnt_d = '0;
            state_d = mdio_i ? S_RREC : S_RDAT;
          end
        end
        S_RDAT: begin
          rsh_d = {rsh_q[DATA_W-2:0], mdio_i};
          if (cnt_q == CNT_W'(DATA_W-1)) begin state_d = S_RCLS; cnt_d = '0; end
          else cnt_d = cnt_q + 1'b1;
        end
        S_RCLS: begin
          if (cnt_q == CNT_W'(1)) begin fin = 1'b1; fin_upd = 1'b1; fin_rd = rsh_q; end
          else cnt_d = cnt_q + 1'b1;
        end
        S_RREC: begin
          if (cnt_q == CNT_W'(RECOV_SLOTS-1)) begin
            fin = 1'b1;  fin_upd = 1'b1;  fin_err = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
    if (fin) begin
      cnt_d = '0;
      if (again_q) begin
        again_d = 1'b0;  state_d = S_PRE;
        o_d = 1'b1;  oe_d = 1'b1;
        hdr_d = mk_hdr(wr_q, addr_q);
      end else begin
        state_d = S_IDLE;  done_d = 1'b1;  err_d = fin_err;
        if (fin_upd) rdata_d = fin_rd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  cnt_q <= '0;  hdr_q <= '0;  wsh_q <= '0;
      rsh_q <= '0;  rdata_q <= '0;  addr_q <= '0;  wr_q <= 1'b0;
      again_q <= 1'b0;  o_q <= 1'b0;  oe_q <= 1'b0;
      done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      state_q <= state_d;  cnt_q <= cnt_d;  hdr_q <= hdr_d;  wsh_q <= wsh_d;
      rsh_q <= rsh_d;  rdata_q <= rdata_d;  addr_q <= addr_d;  wr_q <= wr_d;
      again_q <= again_d;  o_q <= o_d;  oe_q <= oe_d;
      done_q <= done_d;  err_q <= err_d;
    end
  end

  assign run     = (state_q != S_IDLE);
  assign busy    = run;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign done    = done_q;
  assign rdata   = rdata_q;
  assign err     = err_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == '1));
endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdio_reg_pkg::*;
#(
  parameter int                DIV_W       = 16,
  parameter logic [ADDR_W-1:0] DOUBLE_BASE = 10'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic run, slot_end, start;

  assign start = req & ~busy;

  mdio_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .half_period(half_period),
    .mdc(mdc), .slot_end(slot_end)
  );

  mdio_frame_seq #(.DOUBLE_BASE(DOUBLE_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(req_wr), .addr(req_addr),
    .wdata(req_wdata), .slot_end(slot_end), .mdio_i(mdio_i), .run(run),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done),
    .rdata(rdata), .err(err)
  );

  p_mdio_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mdio_oe != $past(mdio_oe)) || (mdio_oe && (mdio_o != $past(mdio_o)))) |-> !mdc);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_reg_master_tb.sv
module mdio_reg_master_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req, req_wr, mdio_i;
  logic [9:0]  req_addr;
  logic [15:0] req_wdata, half_period;
  logic mdc, mdio_o, mdio_oe, busy, done, err;
  logic [15:0] rdata;
  int errs = 0, checks = 0;
  bit finished = 0;

  mdio_reg_master u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .half_period(half_period), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done),
    .rdata(rdata), .err(err)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int frame_len(bit wr, bit present);
    return wr ? 65 : (present ? 66 : 80);
  endfunction

  // expected {oe, o} in MDC cycle k of a frame
  function automatic logic [1:0] exp_pin(bit wr, logic [9:0] a, logic [15:0] wd, int k);
    logic [13:0] h;
    h = {2'b01, (wr ? 2'b01 : 2'b10), a};
    if (k < 32) return 2'b11;
    if (k < 46) return {1'b1, h[13-(k-32)]};
    if (!wr) return 2'b00;
    if (k == 46) return 2'b11;
    if (k == 47) return 2'b10;
    if (k < 64) return {1'b1, wd[15-(k-48)]};
    return 2'b00;
  endfunction

  function automatic logic resp_bit(bit present, logic [15:0] d, int k);
    if (!present) return 1'b1;
    if (k == 47) return 1'b0;
    if (k >= 48 && k < 64) return d[15-(k-48)];
    return 1'b1;
  endfunction

  function automatic string region(bit wr, bit present, bit dbl, int fr, int k);
    if (dbl && fr == 0) return "R7";
    if (k < 34) return "R2";
    if (k < 46) return "R3";
    if (wr) return "R4";
    if (!present) return "R6";
    return "R5";
  endfunction

  task automatic run_op(bit wr, logic [9:0] a, logic [15:0] wd, bit present,
                        int h, bit poke);
    int eh, fl, nfr, slot2, total;
    logic [15:0] dfin, dfirst;
    bit dbl;
    eh    = (h == 0) ? 1 : h;
    dbl   = !wr && (a >= 10'h300);
    nfr   = dbl ? 2 : 1;
    fl    = frame_len(wr, present);
    slot2 = 2 * eh;
    total = nfr * fl * slot2;
    dfin  = {6'h2B, a} ^ 16'h1234;
    dfirst = ~dfin;
    half_period = 16'(h);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd; mdio_i = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t <= total; t++) begin
      if (poke && t == 38) req = 1'b0;
      if (t < total) begin
        int s, p, fr, k;
        logic [1:0] ep;
        string tg;
        s = t / slot2;  p = t % slot2;  fr = s / fl;  k = s % fl;
        mdio_i = resp_bit(present, (dbl && fr == 0) ? dfirst : dfin, k);
        ep = exp_pin(wr, a, wd, k);
        tg = region(wr, present, dbl, fr, k);
        chk(mdc == (p >= eh), "R8", "mdc", int'(mdc), int'(p >= eh));
        chk(mdio_oe == ep[1], tg, "mdio_oe", int'(mdio_oe), int'(ep[1]));
        if (ep[1]) chk(mdio_o == ep[0], tg, "mdio_o", int'(mdio_o), int'(ep[0]));
        chk(busy && !done, "R9", "busy/done", int'({busy, done}), 2);
      end else begin
        mdio_i = 1'b1;
        chk(!busy && done, (wr && a >= 10'h300) ? "R10" : "R9", "end busy/done",
            int'({busy, done}), 1);
        chk(!mdc && !mdio_oe, "R8", "bus idle", int'({mdc, mdio_oe}), 0);
        if (!wr) begin
          if (!present) begin
            chk(rdata == 16'hFFFF, "R6", "rdata", int'(rdata), 16'hFFFF);
            chk(err == 1'b1, "R6", "err", int'(err), 1);
          end else begin
            chk(rdata == dfin, dbl ? "R7" : "R5", "rdata", int'(rdata), int'(dfin));
            chk(err == 1'b0, "R5", "err", int'(err), 0);
          end
        end else chk(err == 1'b0, "R4", "err", int'(err), 0);
      end
      if (poke && t == 37) begin
        req = 1'b1; req_wr = ~wr; req_addr = 10'h3FF;
      end
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      chk(!done && !busy && !mdc, "R9", "after done", int'({done, busy, mdc}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    half_period = 16'd2; mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy && !done, "R1", "in reset",
        int'({mdc, mdio_oe, busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy && !done, "R1", "after reset",
        int'({mdc, mdio_oe, busy, done}), 0);
    run_op(1'b1, 10'h00A, 16'h0001, 1'b1, 2, 1'b0);  // R4
    run_op(1'b0, 10'h2C5, 16'h0000, 1'b1, 2, 1'b0);  // R5
    run_op(1'b0, 10'h0E7, 16'h0000, 1'b0, 1, 1'b0);  // R6
    run_op(1'b0, 10'h301, 16'h0000, 1'b1, 2, 1'b0);  // R7
    run_op(1'b0, 10'h3FE, 16'h0000, 1'b0, 1, 1'b0);  // R7 + R6
    run_op(1'b1, 10'h3A5, 16'hB39C, 1'b1, 1, 1'b0);  // R10
    run_op(1'b1, 10'h155, 16'h8421, 1'b1, 3, 1'b1);  // R9 poke while busy
    run_op(1'b0, 10'h2FF, 16'h0000, 1'b1, 0, 1'b1);  // R8 divider 0
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL R9 watchdog act=hung exp=complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule